// File: doc/BRIEF.md
# Five-channel down-counting PWM timer bank

The bank holds five 32-bit down-counters driven from a shared clock through two 8-bit prescalers and a per-channel power-of-two divider. Channels 0 to 3 each drive a PWM pin whose period and high time come from a count buffer and a compare buffer. Channel 4 has no compare and no pin; it is an interval timer whose live count can be read back. Every channel raises a one-cycle expiry pulse when its counter steps down to zero.

Software programs the buffers through a synchronous word-addressed register port. The active counter and compare copy the buffers only on a 0-to-1 transition of the channel's manual-update bit or on an auto-reload at zero. Each channel runs a four-state machine. IDLE (after reset, nothing loaded) goes to RUN or PAUSE on a load. RUN goes to PAUSE when the start bit clears, and goes to DONE when it reaches zero with auto-reload off. PAUSE goes back to RUN when the start bit is set. DONE holds at zero. A load from any state enters RUN if start is set, or PAUSE if it is not.

Register map (word addresses): 0 prescalers (bits 7:0 for channels 0-1, bits 15:8 for channels 2-4); 1 divider selects (4 bits per channel, channel n at bits 4n+3:4n); 2 control; 3+3n count buffer of channel n; 4+3n compare buffer (channels 0-3); 5+3n current count of channel n (read-only). Control bits for channel n<4: start 4n, manual update 4n+1, auto-reload 4n+3. Channel 4: start 16, manual update 17, auto-reload 18.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset all PWM outputs and expiry pulses are low, and the prescaler, divider, control, buffer and current-count registers read 0.
- R2: Prescaler, divider-select, control and buffer registers read back the last value written. Control keeps only the defined bits (mask 0x7BBBB), and undefined addresses, including address 16, read 0.
- R3: With auto-reload on and count buffer N, consecutive expiry pulses of a channel are (N+1)*(P+1)*2^D clock cycles apart, where P is the channel's prescaler and D its divider select.
- R4: Prescaler bits 7:0 set the rate of channels 0 and 1, and bits 15:8 set the rate of channels 2, 3 and 4.
- R5: A 0-to-1 change of a manual-update bit loads the count and compare buffers into the active counter once. Holding the bit at 1 does not load again.
- R6: Writing a buffer changes nothing in the running channel until the next manual update or auto-reload, and that reload takes the new values.
- R7: Auto-reload uses bit 4n+3 for channels 0-3 and bit 18 for channel 4. A 1 written to bit 19 does not enable reload on channel 4.
- R8: A channel counts only while its start bit is 1. Clearing the bit freezes the count, and setting it again resumes counting from the frozen value.
- R9: With auto-reload off, a channel stops at zero after exactly one expiry pulse and holds 0 until it is loaded again.
- R10: A PWM output is high when its compare C is nonzero and its count is at most C. Over a period of N+1 ticks it is high for C+1 ticks if 1<=C<N, never if C=0, and always if C>=N.
- R11: Each expiry pulse lasts exactly one clock cycle.
- R12: Address 5+3n returns channel n's live count, and for channel 4 it falls by one per tick while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pwm_out | output | 4 | PWM outputs of channels 0-3 |
| expire | output | 5 | One-cycle expiry pulse per channel |

## Verification
The hardest case to reach is a manual-update bit that is left at 1 while the channel keeps running, with a buffer rewritten in the middle of the run. From the ports, an unwanted reload looks just like normal counting unless the live count is watched. The bench therefore runs channel 4 with its update bit still set and reads its live count twice, ten cycles apart. It then rewrites the count buffer and confirms the live count stays below the old period. Only after the update bit is cleared and set again does it expect the new value. Buffered compare changes on a PWM channel are checked by waiting two expiries, so that one auto-reload has certainly passed, before counting high cycles over a full period.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_RUN   = 2'd1,
        CH_PAUSE = 2'd2,
        CH_DONE  = 2'd3
    } ch_state_e;

    // control bit positions; the compare-less channel(s) sit after the PWM group
    function automatic int start_pos(input int ch, input int npwm);
        return (ch < npwm) ? 4 * ch : 4 * npwm;
    endfunction

    function automatic int upd_pos(input int ch, input int npwm);
        return (ch < npwm) ? 4 * ch + 1 : 4 * npwm + 1;
    endfunction

    function automatic int reload_pos(input int ch, input int npwm);
        return (ch < npwm) ? 4 * ch + 3 : 4 * npwm + 2;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] psc_i,
    output logic             tick_o
);
    logic [PSC_W-1:0] cnt_q;

    assign tick_o = (cnt_q >= psc_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3
    tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_divider.sv
module pwm_divider #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_tick_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int CW = (1 << SEL_W) - 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] mask;

    always_comb begin
        mask = (CW'(1) << sel_i) - CW'(1);
    end

    assign tick_o = pre_tick_i && ((cnt_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (pre_tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3
    div_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pre_tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter bit HAS_CMP = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             reload_en_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] cnt_buf_i,
    input  logic [CNT_W-1:0] cmp_buf_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pwm_o,
    output logic             expire_o
);
    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             expire_q;
    logic             step;
    logic             at_zero;
    logic             reload_now;

    assign step       = (state_q == CH_RUN) && start_i && tick_i;
    assign at_zero    = (cnt_q == '0);
    assign reload_now = step && at_zero && reload_en_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d = start_i ? CH_RUN : CH_PAUSE;
        end else begin
            unique case (state_q)
                CH_IDLE:  state_d = CH_IDLE;
                CH_RUN: begin
                    if (!start_i) begin
                        state_d = CH_PAUSE;
                    end else if (tick_i && !reload_en_i && (cnt_q <= CNT_W'(1))) begin
                        state_d = CH_DONE;
                    end
                end
                CH_PAUSE: if (start_i) state_d = CH_RUN;
                CH_DONE:  state_d = CH_DONE;
                default:  state_d = CH_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // counter datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            expire_q <= 1'b0;
        end else begin
            expire_q <= !load_i && step && (cnt_q == CNT_W'(1));
            if (load_i || reload_now) begin
                cnt_q <= cnt_buf_i;
            end else if (step && !at_zero) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign cnt_o    = cnt_q;
    assign expire_o = expire_q;

    generate
        if (HAS_CMP) begin : g_cmp
            logic [CNT_W-1:0] cmp_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cmp_q <= '0;
                end else if (load_i || reload_now) begin
                    cmp_q <= cmp_buf_i;
                end
            end
            // output process
            always_comb begin
                pwm_o = (cmp_q != '0) && (cnt_q <= cmp_q);
            end
        end else begin : g_nocmp
            logic unused_cmp;
            assign unused_cmp = ^cmp_buf_i;
            always_comb begin
                pwm_o = 1'b0;
            end
        end
    endgenerate

    // R8
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !load_i) |=> $stable(cnt_q));

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_DONE && !load_i) |=> (state_q == CH_DONE && cnt_q == '0));

    // R11
    expire_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_q |=> !expire_q);

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH   = 5,
    parameter int NUM_PWM  = 4,
    parameter int GRP_A_CH = 2,
    parameter int CNT_W    = 32,
    parameter int PSC_W    = 8,
    parameter int SEL_W    = 4,
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [NUM_PWM-1:0] pwm_out,
    output logic [NUM_CH-1:0]  expire
);
    localparam int CTRL_W    = 4 * NUM_PWM + 3;
    localparam int SEL_TOT_W = NUM_CH * SEL_W;
    localparam int PSC_TOT_W = 2 * PSC_W;
    localparam int A_PSC     = 0;
    localparam int A_DIV     = 1;
    localparam int A_CTRL    = 2;
    localparam int CH_BASE   = 3;
    localparam int CH_STRIDE = 3;

    function automatic logic [CTRL_W-1:0] build_ctrl_mask();
        logic [CTRL_W-1:0] m;
        m = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            m[start_pos(c, NUM_PWM)]  = 1'b1;
            m[upd_pos(c, NUM_PWM)]    = 1'b1;
            m[reload_pos(c, NUM_PWM)] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [CTRL_W-1:0] CTRL_MASK = build_ctrl_mask();

    logic [PSC_TOT_W-1:0] psc_q;
    logic [SEL_TOT_W-1:0] sel_q;
    logic [CTRL_W-1:0]    ctrl_q;
    logic [CNT_W-1:0]     cnt_buf_q [NUM_CH];
    logic [CNT_W-1:0]     cmp_buf_q [NUM_PWM];
    logic [CNT_W-1:0]     cnt_act   [NUM_CH];
    logic [NUM_CH-1:0]    upd_prev_q;
    logic [NUM_CH-1:0]    load_v;
    logic [1:0]           pre_tick;

    // register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_q  <= '0;
            sel_q  <= '0;
            ctrl_q <= '0;
            for (int n = 0; n < NUM_CH; n++) cnt_buf_q[n] <= '0;
            for (int n = 0; n < NUM_PWM; n++) cmp_buf_q[n] <= '0;
        end else if (reg_wr_en) begin
            if (reg_addr == ADDR_W'(A_PSC))  psc_q  <= reg_wdata[PSC_TOT_W-1:0];
            if (reg_addr == ADDR_W'(A_DIV))  sel_q  <= reg_wdata[SEL_TOT_W-1:0];
            if (reg_addr == ADDR_W'(A_CTRL)) ctrl_q <= reg_wdata[CTRL_W-1:0] & CTRL_MASK;
            for (int n = 0; n < NUM_CH; n++) begin
                if (reg_addr == ADDR_W'(CH_BASE + CH_STRIDE * n))
                    cnt_buf_q[n] <= reg_wdata[CNT_W-1:0];
            end
            for (int n = 0; n < NUM_PWM; n++) begin
                if (reg_addr == ADDR_W'(CH_BASE + CH_STRIDE * n + 1))
                    cmp_buf_q[n] <= reg_wdata[CNT_W-1:0];
            end
        end
    end

    // register reads
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_PSC))  reg_rdata = DATA_W'(psc_q);
        if (reg_addr == ADDR_W'(A_DIV))  reg_rdata = DATA_W'(sel_q);
        if (reg_addr == ADDR_W'(A_CTRL)) reg_rdata = DATA_W'(ctrl_q);
        for (int n = 0; n < NUM_CH; n++) begin
            if (reg_addr == ADDR_W'(CH_BASE + CH_STRIDE * n))
                reg_rdata = DATA_W'(cnt_buf_q[n]);
            if (reg_addr == ADDR_W'(CH_BASE + CH_STRIDE * n + 2))
                reg_rdata = DATA_W'(cnt_act[n]);
        end
        for (int n = 0; n < NUM_PWM; n++) begin
            if (reg_addr == ADDR_W'(CH_BASE + CH_STRIDE * n + 1))
                reg_rdata = DATA_W'(cmp_buf_q[n]);
        end
    end

    // shared prescalers: group 0 and group 1
    generate
        for (genvar g = 0; g < 2; g++) begin : g_psc
            pwm_prescaler #(.PSC_W(PSC_W)) u_psc (
                .clk    (clk),
                .rst_n  (rst_n),
                .psc_i  (psc_q[g*PSC_W +: PSC_W]),
                .tick_o (pre_tick[g])
            );
        end
    endgenerate

    // update-bit edge memory
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_prev_q <= '0;
        end else begin
            for (int n = 0; n < NUM_CH; n++) upd_prev_q[n] <= ctrl_q[upd_pos(n, NUM_PWM)];
        end
    end

    generate
        for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
            localparam int SP  = start_pos(n, NUM_PWM);
            localparam int UP  = upd_pos(n, NUM_PWM);
            localparam int RP  = reload_pos(n, NUM_PWM);
            localparam int GRP = (n < GRP_A_CH) ? 0 : 1;

            logic ch_tick;

            assign load_v[n] = ctrl_q[UP] && !upd_prev_q[n];

            pwm_divider #(.SEL_W(SEL_W)) u_div (
                .clk        (clk),
                .rst_n      (rst_n),
                .pre_tick_i (pre_tick[GRP]),
                .sel_i      (sel_q[n*SEL_W +: SEL_W]),
                .tick_o     (ch_tick)
            );

            if (n < NUM_PWM) begin : g_pwm
                pwm_channel #(.CNT_W(CNT_W), .HAS_CMP(1'b1)) u_chan (
                    .clk         (clk),
                    .rst_n       (rst_n),
                    .tick_i      (ch_tick),
                    .start_i     (ctrl_q[SP]),
                    .reload_en_i (ctrl_q[RP]),
                    .load_i      (load_v[n]),
                    .cnt_buf_i   (cnt_buf_q[n]),
                    .cmp_buf_i   (cmp_buf_q[n]),
                    .cnt_o       (cnt_act[n]),
                    .pwm_o       (pwm_out[n]),
                    .expire_o    (expire[n])
                );
            end else begin : g_tmr
                logic unused_pwm;
                pwm_channel #(.CNT_W(CNT_W), .HAS_CMP(1'b0)) u_chan (
                    .clk         (clk),
                    .rst_n       (rst_n),
                    .tick_i      (ch_tick),
                    .start_i     (ctrl_q[SP]),
                    .reload_en_i (ctrl_q[RP]),
                    .load_i      (load_v[n]),
                    .cnt_buf_i   (cnt_buf_q[n]),
                    .cmp_buf_i   ('0),
                    .cnt_o       (cnt_act[n]),
                    .pwm_o       (unused_pwm),
                    .expire_o    (expire[n])
                );
            end

            // R5
            load_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
                load_v[n] |=> !load_v[n]);
        end
    endgenerate

endmodule

// File: tb/pwm_timer_bank_tb.sv
module pwm_timer_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  pwm_out;
    logic [4:0]  expire;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwm_timer_bank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out),
        .expire    (expire)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_exp(input int ch, output int at);
        at = -1;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (expire[ch]) begin at = cyc; break; end
        end
    endtask

    task automatic count_pulses(input int ch, input int n, output int pulses, output int wide);
        bit prev = 1'b0;
        pulses = 0; wide = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (expire[ch]) pulses++;
            if (expire[ch] && prev) wide++;
            prev = expire[ch];
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check(pwm_out == 0, "R1 pwm_out", pwm_out, 0);
        check(expire == 0, "R1 expire", expire, 0);
        rd(5'd0, v); check(v == 0, "R1 psc", v, 0);
        rd(5'd2, v); check(v == 0, "R1 ctrl", v, 0);
        rd(5'd3, v); check(v == 0, "R1 cnt buf0", v, 0);
        rd(5'd17, v); check(v == 0, "R1 ch4 count", v, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(5'd0, 32'h0000_0302); rd(5'd0, v); check(v == 32'h302, "R2 psc", v, 32'h302);
        wr(5'd1, 32'h000F_1234); rd(5'd1, v); check(v == 32'hF1234, "R2 div", v, 32'hF1234);
        wr(5'd6, 32'hDEAD_BEEF); rd(5'd6, v); check(v == 32'hDEADBEEF, "R2 cnt buf1", v, 32'hDEADBEEF);
        wr(5'd13, 32'h0000_0077); rd(5'd13, v); check(v == 32'h77, "R2 cmp buf3", v, 32'h77);
        wr(5'd2, 32'hFFFF_FFFF); rd(5'd2, v); check(v == 32'h7BBBB, "R2 ctrl mask", v, 32'h7BBBB);
        wr(5'd2, 32'h0);
        wr(5'd16, 32'h1234); rd(5'd16, v); check(v == 0, "R2 addr16", v, 0);
        wr(5'd31, 32'h1234); rd(5'd31, v); check(v == 0, "R2 addr31", v, 0);
        wr(5'd0, 32'h0); wr(5'd1, 32'h0);
    endtask

    task automatic t_rate();
        int a, b;
        wr(5'd2, 32'h0);
        wr(5'd0, 32'h0000_0200);   // group A = 0, group B = 2
        wr(5'd1, 32'h0000_0020);   // ch1 divide by 4
        wr(5'd3, 32'd4); wr(5'd6, 32'd4); wr(5'd9, 32'd4);
        wr(5'd2, 32'h0000_0BBB);
        wait_exp(0, a); wait_exp(0, b);
        check(b - a == 5, "R3 ch0 interval", b - a, 5);
        wait_exp(1, a); wait_exp(1, b);
        check(b - a == 20, "R3 ch1 divider interval", b - a, 20);
        wait_exp(2, a); wait_exp(2, b);
        check(b - a == 15, "R4 ch2 group B prescaler", b - a, 15);
        wr(5'd2, 32'h0);
        wr(5'd0, 32'h0); wr(5'd1, 32'h0);
    endtask

    task automatic duty_window(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[3]) hi++;
        end
    endtask

    task automatic t_duty();
        int t, hi;
        wr(5'd2, 32'h0);
        wr(5'd12, 32'd9); wr(5'd13, 32'd3);
        wr(5'd2, 32'h0000_B000);
        wait_exp(3, t);
        duty_window(10, hi); check(hi == 4, "R10 cmp 3 of 9", hi, 4);
        wr(5'd13, 32'd0);
        wait_exp(3, t); wait_exp(3, t);
        duty_window(10, hi); check(hi == 0, "R10 cmp 0 low", hi, 0);
        wr(5'd13, 32'd12);
        wait_exp(3, t); wait_exp(3, t);
        duty_window(10, hi); check(hi == 10, "R10 cmp above count high", hi, 10);
        wr(5'd13, 32'd9);
        wait_exp(3, t); wait_exp(3, t);
        duty_window(10, hi); check(hi == 10, "R10 cmp equal count high", hi, 10);
        wr(5'd2, 32'h0);
    endtask

    task automatic t_expire();
        int t, p, w;
        wr(5'd2, 32'h0);
        wr(5'd3, 32'd3);
        wr(5'd2, 32'h0000_000B);
        wait_exp(0, t);
        count_pulses(0, 40, p, w);
        check(p == 10, "R11 pulse count", p, 10);
        check(w == 0, "R11 pulse width one cycle", w, 0);
        wr(5'd2, 32'h0);
    endtask

    task automatic t_update();
        logic [31:0] a, b, c;
        wr(5'd2, 32'h0);
        wr(5'd15, 32'd1000);
        wr(5'd2, 32'h0003_0000);            // ch4 start + update, no reload
        repeat (3) @(negedge clk);
        rd(5'd17, a);
        repeat (9) @(negedge clk);
        rd(5'd17, b);
        check(a - b == 10, "R12 ch4 live count step", a - b, 10);
        check(b < 1000, "R5 update held set no repeat", b, 990);
        wr(5'd15, 32'd50000);
        rd(5'd17, c);
        check(c < 1000, "R6 buffer write no effect", c, 990);
        wr(5'd2, 32'h0);
        wr(5'd2, 32'h0003_0000);
        repeat (3) @(negedge clk);
        rd(5'd17, c);
        check(c > 40000 && c <= 50000, "R5 reload on new edge", c, 50000);
    endtask

    task automatic t_start();
        logic [31:0] a, b;
        wr(5'd2, 32'h0002_0000);            // keep update, clear start
        rd(5'd17, a);
        repeat (19) @(negedge clk);
        rd(5'd17, b);
        check(a == b, "R8 stopped count frozen", b, a);
        wr(5'd2, 32'h0003_0000);
        repeat (3) @(negedge clk);
        rd(5'd17, a);
        repeat (9) @(negedge clk);
        rd(5'd17, b);
        check(a - b == 10, "R8 resumed counting", a - b, 10);
        wr(5'd2, 32'h0);
    endtask

    task automatic t_oneshot();
        int p, w;
        logic [31:0] v;
        wr(5'd2, 32'h0);
        wr(5'd15, 32'd5);
        wr(5'd2, 32'h0003_0000);
        count_pulses(4, 30, p, w);
        check(p == 1, "R9 single expiry", p, 1);
        rd(5'd17, v);
        check(v == 0, "R9 holds zero", v, 0);
    endtask

    task automatic t_reload4();
        int p, w, t;
        wr(5'd2, 32'h0);
        wr(5'd15, 32'd5);
        wr(5'd2, 32'h000B_0000);            // bit 19 is not reload
        count_pulses(4, 40, p, w);
        check(p == 1, "R7 bit19 no reload", p, 1);
        wr(5'd2, 32'h0);
        wr(5'd2, 32'h0007_0000);            // bit 18 reload
        wait_exp(4, t);
        count_pulses(4, 36, p, w);
        check(p == 6, "R7 bit18 reload ch4", p, 6);
        wr(5'd2, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_rate();
        t_duty();
        t_expire();
        t_update();
        t_start();
        t_oneshot();
        t_reload4();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule